// File: doc/BRIEF.md
# Exhaustive Parity-Checked Logic Self-Test

This block runs a built-in self-test over several groups of combinational blocks under test. Every block has the same input width. Each group owns a pattern generator. The generator is a linear feedback shift register, modified so that it also enters the all-zero state, and it therefore steps through every input combination exactly once. Every block in a group receives the same pattern in the same cycle, and all blocks across all groups are exercised together.

Responses are not compressed into a signature. A constant table, given as a parameter, holds one bit per group and per pattern: the XOR of what all blocks in that group should return for that pattern. One register stage after the pattern is applied, each group XORs its captured block outputs with the delayed predicted bit. A nonzero result sets a sticky fail flag. Any odd number of wrong outputs in a group is therefore caught, while an even number cancels out. A second mode drives every ordered pair of patterns on back-to-back cycles, so that faults which depend on the previous input are exposed. The blocks under test sit outside the wrapper: the wrapper drives their inputs and receives their outputs.

The controller is a four-state machine. IDLE waits after reset. Any `start_i` pulse moves it to RUN, from any state. RUN stays in RUN until the last pattern has been applied, then moves to DRAIN. DRAIN lasts one cycle, so that the final response is compared, and then moves to DONE. DONE holds until the next `start_i`.

Top module: `lbist_parity_top`

## Requirements
- R1: While and after an active-low reset, `busy_o`, `done_o` and `fail_o` are 0 and `pat_o` is all zeros.
- R2: A cycle with `start_i` high has the following effect at the next edge, even in the middle of a run: `busy_o` is 1, `fail_o` is 0, `done_o` is 0 and every group's pattern is all zeros.
- R3: With `xfer_mode_i` = 0 (exhaustive), each group applies all 2^N_IN patterns, one per cycle, starting at zero. No value repeats and no pattern appears on two consecutive cycles.
- R4: Each group's slice of `pat_o` (group g at bits g*N_IN upward) carries the same value as every other group's slice in every cycle.
- R5: With `xfer_mode_i` = 1 (pair mode), all 2^(2*N_IN) ordered pairs (a, b) are applied as a then b on consecutive cycles. The first element of the pair is held while the second element sweeps all values.
- R6: For group g, the parity check compares the XOR of its M_DUT response bits (`resp_i` bits g*M_DUT upward) with bit g*2^N_IN + pattern of `PARITY_TABLE`. A single wrong response bit on any applied pattern sets `fail_o`.
- R7: An odd count of wrong bits within one group on one pattern is flagged. An even count within that group is not flagged.
- R8: A mismatch on the pattern visible in cycle t makes `fail_o` high in cycle t+2 and not before.
- R9: `fail_o` stays high until the next `start_i`, including through DONE.
- R10: `done_o` rises at the (T+1)-th edge after the edge that samples `start_i`. T is 2^N_IN in exhaustive mode and 2^(2*N_IN+1) in pair mode. `busy_o` falls at that same edge, and the two are never high together.
- R11: A fault that flips a response only when a pattern directly follows itself is caught in pair mode and is not caught in exhaustive mode.
- R12: `xfer_mode_i` is sampled only on the `start_i` cycle. Changing it during a run changes neither the sequence nor the end time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin or restart a test run |
| xfer_mode_i | input | 1 | 0 exhaustive, 1 ordered-pair mode; sampled with start |
| pat_o | output | GROUPS*N_IN | Pattern to each group's blocks under test |
| resp_i | input | GROUPS*M_DUT | Outputs of all blocks under test |
| busy_o | output | 1 | High in RUN and DRAIN |
| done_o | output | 1 | High in DONE |
| fail_o | output | 1 | Sticky OR of all group mismatches |

## Verification
The bench drives inputs and samples outputs on falling edges. It counts falling edges from the one that follows the start edge. The pattern of run step k is visible on count k+1. A mismatch on that pattern appears on `fail_o` two counts later. `done_o` is due on count T+2 and must still be low on count T+1. Every scenario checks these exact counts rather than a time window, and the bound checker ties the rise of `done_o` to a counted run length.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } bist_state_e;

    typedef enum logic {
        MODE_EXH  = 1'b0,
        MODE_PAIR = 1'b1
    } bist_mode_e;

endpackage

// File: rtl/bist_debruijn.sv
module bist_debruijn #(
    parameter int N = 4,
    parameter logic [N-1:0] TAPS = 4'b1100
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         adv_i,
    output logic [N-1:0] state_o
);

    logic [N-1:0] q;
    logic         lin_fb;
    logic         zero_fix;
    logic         fb;

    // Plain LFSR feedback, plus a correction that splices the all-zero
    // state into the maximal-length cycle.
    always_comb begin
        lin_fb   = ^(q & TAPS);
        zero_fix = (q[N-2:0] == '0);
        fb       = lin_fb ^ zero_fix;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else if (clr_i) begin
            q <= '0;
        end else if (adv_i) begin
            q <= {q[N-2:0], fb};
        end
    end

    assign state_o = q;

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
    import bist_pkg::*;
#(
    parameter int N = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic mode_i,
    output logic clr_o,
    output logic adv_a_o,
    output logic adv_b_o,
    output logic sel_b_o,
    output logic vld_o,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = 2 * N + 2;
    localparam logic [CW-1:0] EXH_LAST  = CW'((2 ** N) - 1);
    localparam logic [CW-1:0] PAIR_LAST = CW'((2 ** (2 * N + 1)) - 1);

    bist_state_e   state_q, state_d;
    bist_mode_e    mode_q;
    logic [CW-1:0] cnt_q;
    logic          last_step;
    logic          stepping;
    logic          pair_end;

    assign last_step = (cnt_q == ((mode_q == MODE_PAIR) ? PAIR_LAST : EXH_LAST));

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_RUN:   state_d = last_step ? ST_DRAIN : ST_RUN;
                ST_DRAIN: state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
            endcase
        end
    end

    // Step counter and latched mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            mode_q <= MODE_EXH;
        end else if (start_i) begin
            cnt_q  <= '0;
            mode_q <= bist_mode_e'(mode_i);
        end else if (state_q == ST_RUN) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        stepping = (state_q == ST_RUN) && !start_i;
        pair_end = cnt_q[0] && (&cnt_q[N:1]);
        clr_o    = start_i;
        vld_o    = (state_q == ST_RUN);
        busy_o   = (state_q == ST_RUN) || (state_q == ST_DRAIN);
        done_o   = (state_q == ST_DONE);
        sel_b_o  = (mode_q == MODE_PAIR) && cnt_q[0];
        adv_b_o  = stepping && (mode_q == MODE_PAIR) && cnt_q[0];
        adv_a_o  = stepping && ((mode_q == MODE_EXH) || pair_end);
    end

endmodule

// File: rtl/bist_group.sv
module bist_group #(
    parameter int N = 4,
    parameter int M = 3,
    parameter logic [N-1:0] TAPS = 4'b1100,
    parameter logic [(2**N)-1:0] TABLE = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         adv_a_i,
    input  logic         adv_b_i,
    input  logic         sel_b_i,
    input  logic         vld_i,
    output logic [N-1:0] pat_o,
    input  logic [M-1:0] resp_i,
    output logic         fail_o
);

    logic [1:0]   adv;
    logic [N-1:0] gen_q [2];
    logic         pred;
    logic [M-1:0] resp_q;
    logic         pred_q;
    logic         vld_q;
    logic         mism;
    logic         fail_q;

    assign adv = {adv_b_i, adv_a_i};

    // Two generators: index 0 leads the pair, index 1 follows it
    for (genvar k = 0; k < 2; k++) begin : g_gen
        bist_debruijn #(.N(N), .TAPS(TAPS)) u_gen (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (clr_i),
            .adv_i   (adv[k]),
            .state_o (gen_q[k])
        );
    end

    assign pat_o = sel_b_i ? gen_q[1] : gen_q[0];
    assign pred  = TABLE[pat_o];

    // One pipeline stage, with the predicted bit kept in step with the responses
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            resp_q <= '0;
            pred_q <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            resp_q <= resp_i;
            pred_q <= pred;
            vld_q  <= clr_i ? 1'b0 : vld_i;
        end
    end

    assign mism = vld_q && ((^resp_q) ^ pred_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fail_q <= 1'b0;
        end else if (clr_i) begin
            fail_q <= 1'b0;
        end else if (mism) begin
            fail_q <= 1'b1;
        end
    end

    assign fail_o = fail_q;

endmodule

// File: rtl/lbist_parity_top.sv
module lbist_parity_top #(
    parameter int N_IN   = 4,
    parameter int M_DUT  = 3,
    parameter int GROUPS = 2,
    parameter logic [N_IN-1:0] TAPS = 4'b1100,
    parameter logic [GROUPS*(2**N_IN)-1:0] PARITY_TABLE = '0
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      start_i,
    input  logic                      xfer_mode_i,
    output logic [GROUPS*N_IN-1:0]    pat_o,
    input  logic [GROUPS*M_DUT-1:0]   resp_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      fail_o
);

    localparam int DEPTH = 2 ** N_IN;

    logic              clr;
    logic              adv_a;
    logic              adv_b;
    logic              sel_b;
    logic              vld;
    logic [GROUPS-1:0] grp_fail;

    bist_ctrl #(.N(N_IN)) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .mode_i  (xfer_mode_i),
        .clr_o   (clr),
        .adv_a_o (adv_a),
        .adv_b_o (adv_b),
        .sel_b_o (sel_b),
        .vld_o   (vld),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        bist_group #(
            .N     (N_IN),
            .M     (M_DUT),
            .TAPS  (TAPS),
            .TABLE (PARITY_TABLE[g*DEPTH +: DEPTH])
        ) u_grp (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clr_i   (clr),
            .adv_a_i (adv_a),
            .adv_b_i (adv_b),
            .sel_b_i (sel_b),
            .vld_i   (vld),
            .pat_o   (pat_o[g*N_IN +: N_IN]),
            .resp_i  (resp_i[g*M_DUT +: M_DUT]),
            .fail_o  (grp_fail[g])
        );
    end

    assign fail_o = |grp_fail;

endmodule

// File: rtl/lbist_parity_chk.sv
module lbist_parity_chk #(
    parameter int N_IN   = 4,
    parameter int GROUPS = 2
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   start_i,
    input logic                   xfer_mode_i,
    input logic [GROUPS*N_IN-1:0] pat_o,
    input logic                   busy_o,
    input logic                   done_o,
    input logic                   fail_o
);

    localparam int CW = 2 * N_IN + 3;
    localparam logic [CW-1:0] EXH_SPAN  = CW'((2 ** N_IN) + 1);
    localparam logic [CW-1:0] PAIR_SPAN = CW'((2 ** (2 * N_IN + 1)) + 1);

    logic          mode_q;
    logic [CW-1:0] span_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q <= 1'b0;
            span_q <= '0;
        end else if (start_i) begin
            mode_q <= xfer_mode_i;
            span_q <= '0;
        end else if (busy_o) begin
            span_q <= span_q + 1'b1;
        end
    end

    assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (busy_o && !fail_o && !done_o && (pat_o[N_IN-1:0] == '0)));

    assert_busy_from_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));

    assert_exh_no_repeat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && !$past(start_i) && !mode_q)
            |-> (pat_o[N_IN-1:0] != $past(pat_o[N_IN-1:0])));

    assert_fail_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fail_o && !start_i) |=> fail_o);

    assert_busy_done_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o));

    assert_done_span_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> (span_q == (mode_q ? PAIR_SPAN : EXH_SPAN)));

    for (genvar g = 1; g < GROUPS; g++) begin : g_same
        assert_groups_same_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            pat_o[g*N_IN +: N_IN] == pat_o[N_IN-1:0]);
    end

endmodule

bind lbist_parity_top lbist_parity_chk #(.N_IN(N_IN), .GROUPS(GROUPS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .xfer_mode_i (xfer_mode_i),
    .pat_o       (pat_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fail_o      (fail_o)
);

// File: tb/tb_lbist_parity_top.sv
module tb_lbist_parity_top;

    localparam int N = 4;
    localparam int M = 3;
    localparam int G = 2;
    localparam int D = 16;

    function automatic logic but_fn(input int g, input int b, input logic [3:0] p);
        logic gs;
        gs = (g == 1);
        case (b)
            0:       return (^p) ^ gs;
            1:       return (p[0] & p[1]) | (gs & p[3]);
            default: return (p[3:2] == p[1:0]) ^ (gs & p[2]);
        endcase
    endfunction

    function automatic logic [G*D-1:0] build_tab();
        logic [G*D-1:0] t;
        t = '0;
        for (int g = 0; g < G; g++) begin
            for (int v = 0; v < D; v++) begin
                t[g*D+v] = but_fn(g, 0, 4'(v)) ^ but_fn(g, 1, 4'(v)) ^ but_fn(g, 2, 4'(v));
            end
        end
        return t;
    endfunction

    localparam logic [G*D-1:0] PTAB = build_tab();

    // {mode, kind[2:0], grp, pat[3:0], expected fail}
    // kind: 0 none, 1 one bit, 2 two bits, 3 repeat-only, 4 three bits
    localparam logic [9:0] SCN [0:8] = '{
        {1'b0, 3'd0, 1'b0, 4'd0,  1'b0},
        {1'b1, 3'd0, 1'b0, 4'd0,  1'b0},
        {1'b0, 3'd1, 1'b0, 4'd0,  1'b1},
        {1'b0, 3'd1, 1'b1, 4'd15, 1'b1},
        {1'b0, 3'd2, 1'b0, 4'd7,  1'b0},
        {1'b0, 3'd3, 1'b1, 4'd5,  1'b0},
        {1'b1, 3'd3, 1'b1, 4'd5,  1'b1},
        {1'b1, 3'd1, 1'b1, 4'd9,  1'b1},
        {1'b0, 3'd4, 1'b0, 4'd11, 1'b1}
    };

    logic           clk;
    logic           rst_n;
    logic           start;
    logic           xmode;
    logic [G*N-1:0] pat;
    logic [G*M-1:0] resp;
    logic           busy;
    logic           done;
    logic           fail;
    logic [G*N-1:0] prev_pat;
    int             inj_kind;
    int             inj_grp;
    logic [3:0]     inj_pat;
    int             n_chk;
    int             n_bad;

    lbist_parity_top #(
        .N_IN(N), .M_DUT(M), .GROUPS(G), .TAPS(4'b1100), .PARITY_TABLE(PTAB)
    ) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .xfer_mode_i(xmode),
        .pat_o(pat), .resp_i(resp), .busy_o(busy), .done_o(done), .fail_o(fail)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    always_ff @(posedge clk) prev_pat <= pat;

    always_comb begin
        resp = '0;
        for (int g = 0; g < G; g++) begin
            for (int b = 0; b < M; b++) begin
                logic [3:0] cur;
                logic       flip;
                cur  = pat[g*N +: N];
                flip = 1'b0;
                if (g == inj_grp && cur == inj_pat) begin
                    case (inj_kind)
                        1: flip = (b == 0);
                        2: flip = (b < 2);
                        3: flip = (b == 1) && (prev_pat[g*N +: N] == inj_pat);
                        4: flip = 1'b1;
                        default: flip = 1'b0;
                    endcase
                end
                resp[g*M+b] = but_fn(g, b, cur) ^ flip;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_scn(input logic [9:0] s);
        logic       mode;
        int         kind;
        int         T;
        logic [15:0]  seen;
        logic [255:0] pseen;
        logic [3:0] first_pat;
        logic [3:0] lead;
        int         grp_diff;
        int         first_apply;
        int         first_fail;
        int         drops;
        string      tag;
        mode      = s[9];
        kind      = int'(s[8:6]);
        T         = mode ? 512 : 16;
        tag       = (kind == 2 || kind == 4) ? "R7" : (kind == 3 ? "R11" : "R6");
        inj_kind  = kind;
        inj_grp   = int'(s[5]);
        inj_pat   = s[4:1];
        seen = '0; pseen = '0; grp_diff = 0; drops = 0;
        first_apply = -1; first_fail = -1; first_pat = '0; lead = '0;
        xmode = mode;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= T + 2; c++) begin
            if (c > 1) @(negedge clk);
            if (c <= T) begin
                if (c == 1) first_pat = pat[N-1:0];
                seen[pat[N-1:0]] = 1'b1;
                if (c % 2 == 1) lead = pat[N-1:0];
                else pseen[{lead, pat[N-1:0]}] = 1'b1;
                if (pat[2*N-1:N] != pat[N-1:0]) grp_diff++;
                if (first_apply < 0 && pat[inj_grp*N +: N] == inj_pat) first_apply = c;
            end
            if (fail && first_fail < 0) first_fail = c;
            if (first_fail >= 0 && !fail) drops++;
            if (c == T + 1) chk(!done && busy, "R10", int'(done), 0, "done before run end");
            if (c == T + 2) chk(done && !busy, "R10", int'(done), 1, "done at run end");
        end
        chk(fail == s[0], tag, int'(fail), int'(s[0]), "fail result");
        chk(grp_diff == 0, "R4", grp_diff, 0, "cycles with differing group patterns");
        if (kind == 0 && !mode) begin
            chk(seen == 16'hFFFF && first_pat == 4'd0, "R3", int'($countones(seen)), 16, "distinct patterns");
        end
        if (kind == 0 && mode) begin
            chk(pseen == {256{1'b1}}, "R5", int'($countones(pseen)), 256, "distinct ordered pairs");
        end
        if (kind == 1 && !mode) begin
            chk(first_fail - first_apply == 2, "R8", first_fail - first_apply, 2, "fail latency");
        end
        if (s[0]) chk(drops == 0, "R9", drops, 0, "cycles fail dropped");
        inj_kind = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        n_chk = 0; n_bad = 0;
        rst_n = 1'b0; start = 1'b0; xmode = 1'b0;
        inj_kind = 0; inj_grp = 0; inj_pat = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && pat == '0, "R1", int'(pat), 0, "state in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fail && pat == '0, "R1", int'(pat), 0, "state after reset");

        for (int i = 0; i < 9; i++) run_scn(SCN[i]);

        // Restart mid-run in pair mode with a fault on the first pattern
        inj_kind = 1; inj_grp = 0; inj_pat = 4'd0;
        xmode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk(fail, "R9", int'(fail), 1, "fail raised before restart");
        inj_kind = 0; xmode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !fail && !done && pat == '0, "R2", int'(fail), 0, "restart clears state");
        xmode = 1'b1;
        repeat (16) @(negedge clk);
        chk(!done, "R12", int'(done), 0, "done not early after mode change");
        @(negedge clk);
        chk(done && !busy, "R12", int'(done), 1, "exhaustive end time kept");
        chk(!fail, "R12", int'(fail), 0, "clean run after restart");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule